// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the slave side of a small serial NOR flash seen over a four-wire SPI link in mode 0. The link is made of a chip select, a serial clock, a data input and a data output. The block oversamples the link in its own clock domain and collects 8-bit bus cycles. It decodes the first cycle as an opcode and then runs the instruction against an on-chip byte array of 2^ADDR_W entries. The array starts erased.

The instructions cover:
- reading the array, the status byte and the identification bytes;
- programming one byte, and programming a sequential run of bytes;
- erasing a sector, a block or the whole array;
- setting and clearing a write-enable latch;
- changing the writable status bits.

Instructions that write only take effect when chip select rises exactly at the end of their last byte. Only the status read can be used while the array is busy. Busy lasts for a fixed number of clocks after a program, and for one clock per byte during an erase. At power-up the block sweeps the whole array to the erased value.

Top module: `spi_nor_front`

## Requirements
- R1: Every bus cycle is 8 rising SCK edges, sampled MSB first. Output bits change on SCK falling edges, MSB first. `spi_miso_oe` is 1 only during the output phase of a read, status-read or ID-read instruction, and it goes to 0 once chip select is high.
- R2: When chip select rises partway through a byte, the instruction is discarded. An instruction with any whole bytes beyond its format is also discarded.
- R3: The status byte holds busy in bit 0, the write-enable latch in bit 1, four protection bits in bits 5:2, the sequential-program flag in bit 6 and a lock bit in bit 7. After the power-up sweep it reads 00h. Opcode 05h returns the status byte again for every following byte while chip select stays low.
- R4: Opcode 06h sets the write-enable latch. Opcode 04h clears the latch and leaves sequential-program mode.
- R5: The program and erase opcodes are ignored while the latch is clear. A completed byte program or erase clears the latch.
- R6: Opcode 02h takes three address bytes (upper first) and one data byte. It writes the bitwise AND of the data and the old contents. Address bits at and above ADDR_W are ignored.
- R7: Opcode 03h takes three address bytes and then streams bytes from successive addresses. The address wraps from the top of the array to 0.
- R8: Opcode AFh with an address and a data byte writes that byte, sets status bit 6 and keeps the latch set. After that, AFh followed by one data byte writes to the next address. In this mode only AFh, 04h and 05h are accepted.
- R9: Opcode 20h erases the sector addressed by the bits above SECT_BITS. Opcode 52h erases the block addressed by the bits above BLK_BITS. Opcode 60h erases the whole array. Erased bytes read FFh, and bytes outside the range keep their value.
- R10: Opcode 01h with one data byte copies data bits 7 and 5:2 into the status byte. It does so only when the instruction completed just before it was 50h.
- R11: Opcodes 90h and ABh take two don't-care bytes and an ID address byte. They return DEV_ID when bit 0 of that byte is 1 and MFR_ID when it is 0. The two IDs then alternate while chip select stays low.
- R12: Status bit 0 is 1 during the power-up sweep and during erases, and for BUSY_CYC clocks after a program. Every opcode except 05h is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset; starts the erase sweep |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
The bench builds the block with ADDR_W=10, SECT_BITS=6, BLK_BITS=9 and BUSY_CYC=4. With these values the power-up sweep and the chip erase take about a thousand clocks. Several sectors and two blocks fit in the small array, so sector and block erase can be shown to leave neighbouring bytes intact. The read wrap at 3FFh and the discarding of upper address bits are also within reach.

// File: rtl/spi_nor_front.sv
module spi_nor_front #(
  parameter int ADDR_W = 12,
  parameter int SECT_BITS = 8,
  parameter int BLK_BITS = 11,
  parameter int BUSY_CYC = 4,
  parameter logic [7:0] MFR_ID = 8'hC5,
  parameter logic [7:0] DEV_ID = 8'h48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 2);
  localparam logic [ADDR_W-1:0] SMASK = ADDR_W'((1 << SECT_BITS) - 1);
  localparam logic [ADDR_W-1:0] BMASK = ADDR_W'((1 << BLK_BITS) - 1);
  localparam logic [7:0] OP_READ = 8'h03, OP_SE = 8'h20, OP_BE = 8'h52, OP_CE = 8'h60,
                         OP_BP = 8'h02, OP_AAI = 8'hAF, OP_RDSR = 8'h05, OP_EWSR = 8'h50,
                         OP_WRSR = 8'h01, OP_WREN = 8'h06, OP_WRDI = 8'h04,
                         OP_ID1 = 8'h90, OP_ID2 = 8'hAB;

  logic [7:0] mem [DEPTH];
  logic sck_q, cs_q;
  logic [2:0] bitn, nbytes;
  logic [7:0] shreg, op, osh;
  logic [ADDR_W-1:0] adr, ptr, er_ptr, er_end;
  logic out_ph, id_sel, cmd_ok;
  logic wel, aai, bpl, erasing, ewsr_arm, pair_ok;
  logic [3:0] bp;
  logic [CNT_W-1:0] prog_cnt;

  wire sck_rise = spi_sck & ~sck_q & ~spi_cs_n;
  wire sck_fall = ~spi_sck & sck_q & ~spi_cs_n;
  wire cs_rise = spi_cs_n & ~cs_q;
  wire [7:0] byte_in = {shreg[6:0], spi_mosi};
  wire busy = erasing | (prog_cnt != '0);
  wire [7:0] status = {bpl, aai, bp, wel, busy};
  wire [ADDR_W-1:0] adr_nx = ADDR_W'({adr, byte_in});
  wire [ADDR_W-1:0] la = (nbytes == 3'd3) ? adr_nx : ptr;
  wire id_now = (nbytes == 3'd3) ? byte_in[0] : id_sel;

  wire done_ok = cs_rise && bitn == 3'd0 && !busy;
  wire ex_wren = done_ok && op == OP_WREN && nbytes == 3'd1 && !aai;
  wire ex_wrdi = done_ok && op == OP_WRDI && nbytes == 3'd1;
  wire ex_ewsr = done_ok && op == OP_EWSR && nbytes == 3'd1 && !aai;
  wire ex_wrsr = done_ok && op == OP_WRSR && nbytes == 3'd2 && pair_ok && !aai;
  wire ex_bp   = done_ok && op == OP_BP && nbytes == 3'd5 && wel && !aai;
  wire ex_aai1 = done_ok && op == OP_AAI && nbytes == 3'd5 && wel && !aai;
  wire ex_aain = done_ok && op == OP_AAI && nbytes == 3'd2 && aai;
  wire ex_se   = done_ok && op == OP_SE && nbytes == 3'd4 && wel && !aai;
  wire ex_be   = done_ok && op == OP_BE && nbytes == 3'd4 && wel && !aai;
  wire ex_ce   = done_ok && op == OP_CE && nbytes == 3'd1 && wel && !aai;
  wire wr_en = ex_bp | ex_aai1 | ex_aain;
  wire [ADDR_W-1:0] wr_addr = ex_aain ? ptr : adr;

  always_ff @(posedge clk) begin
    if (erasing) mem[er_ptr] <= 8'hFF;
    else if (wr_en) mem[wr_addr] <= mem[wr_addr] & shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bitn <= '0; nbytes <= '0; shreg <= '0; op <= '0;
      osh <= '0; adr <= '0; ptr <= '0; out_ph <= 1'b0; id_sel <= 1'b0; cmd_ok <= 1'b0;
      spi_miso <= 1'b0; spi_miso_oe <= 1'b0;
      wel <= 1'b0; aai <= 1'b0; bpl <= 1'b0; bp <= '0;
      erasing <= 1'b1; er_ptr <= '0; er_end <= '1; prog_cnt <= '0;
      ewsr_arm <= 1'b0; pair_ok <= 1'b0;
    end else begin
      sck_q <= spi_sck;
      cs_q <= spi_cs_n;
      if (spi_cs_n) begin
        bitn <= '0; nbytes <= '0; out_ph <= 1'b0; spi_miso_oe <= 1'b0;
      end else if (sck_rise) begin
        shreg <= byte_in;
        bitn <= bitn + 3'd1;
        if (bitn == 3'd7) begin
          if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
          if (nbytes == 3'd0) begin
            op <= byte_in;
            cmd_ok <= !busy && !aai;
            pair_ok <= ewsr_arm;
            ewsr_arm <= 1'b0;
            if (byte_in == OP_RDSR) begin osh <= status; out_ph <= 1'b1; end
          end else begin
            if (nbytes <= 3'd3) adr <= adr_nx;
            if (op == OP_RDSR) osh <= status;
            else if (cmd_ok && op == OP_READ && nbytes >= 3'd3) begin
              osh <= mem[la]; ptr <= la + 1'b1; out_ph <= 1'b1;
            end else if (cmd_ok && (op == OP_ID1 || op == OP_ID2) && nbytes >= 3'd3) begin
              osh <= id_now ? DEV_ID : MFR_ID; id_sel <= ~id_now; out_ph <= 1'b1;
            end
          end
        end
      end else if (sck_fall) begin
        spi_miso <= osh[7];
        osh <= {osh[6:0], 1'b0};
        spi_miso_oe <= out_ph;
      end

      if (erasing) begin
        if (er_ptr == er_end) erasing <= 1'b0;
        else er_ptr <= er_ptr + 1'b1;
      end
      if (prog_cnt != '0) prog_cnt <= prog_cnt - 1'b1;

      if (ex_wren) wel <= 1'b1;
      if (ex_wrdi) begin wel <= 1'b0; aai <= 1'b0; end
      if (ex_ewsr) ewsr_arm <= 1'b1;
      if (ex_wrsr) begin bpl <= shreg[7]; bp <= shreg[5:2]; end
      if (ex_bp) begin wel <= 1'b0; prog_cnt <= CNT_W'(BUSY_CYC); end
      if (ex_aai1) begin aai <= 1'b1; ptr <= adr + 1'b1; prog_cnt <= CNT_W'(BUSY_CYC); end
      if (ex_aain) begin ptr <= ptr + 1'b1; prog_cnt <= CNT_W'(BUSY_CYC); end
      if (ex_se) begin er_ptr <= adr & ~SMASK; er_end <= adr | SMASK; erasing <= 1'b1; wel <= 1'b0; end
      if (ex_be) begin er_ptr <= adr & ~BMASK; er_end <= adr | BMASK; erasing <= 1'b1; wel <= 1'b0; end
      if (ex_ce) begin er_ptr <= '0; er_end <= '1; erasing <= 1'b1; wel <= 1'b0; end
    end
  end

  a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !spi_miso_oe);
  a_r2_abort_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bitn != 3'd0) |=> $stable({wel, aai, bpl, bp, erasing}));
  a_r5_erase_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erasing) |-> $past(wel));
  a_r8_aai_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> (wel && !erasing));
  a_r10_status_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ({bpl, bp} != $past({bpl, bp})) |-> $past(pair_ok));
endmodule

// File: tb/test_spi_nor_front.sv
module test_spi_nor_front;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, oe;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_nor_front #(.ADDR_W(10), .SECT_BITS(6), .BLK_BITS(9), .BUSY_CYC(4),
                  .MFR_ID(8'hC5), .DEV_ID(8'h48)) i_spi_nor_front (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sel();
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic desel();
    repeat (2) @(posedge clk); #1 cs_n = 1'b1;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] r, output logic oe_s);
    oe_s = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (3) @(posedge clk); #1;
      r[i] = miso;
      oe_s = oe_s & oe;
      sck = 1'b1;
      repeat (3) @(posedge clk); #1;
      sck = 1'b0;
    end
  endtask

  task automatic op1(input logic [7:0] o);
    logic [7:0] r; logic s;
    sel(); xb(o, r, s); desel();
  endtask

  task automatic op2(input logic [7:0] o, input logic [7:0] d);
    logic [7:0] r; logic s;
    sel(); xb(o, r, s); xb(d, r, s); desel();
  endtask

  task automatic opa(input logic [7:0] o, input logic [23:0] a, input bit has_d, input logic [7:0] d);
    logic [7:0] r; logic s;
    sel(); xb(o, r, s); xb(a[23:16], r, s); xb(a[15:8], r, s); xb(a[7:0], r, s);
    if (has_d) xb(d, r, s);
    desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r; logic s;
    sel(); xb(8'h05, r, s); xb(8'h00, st, s); desel();
  endtask

  task automatic rd(input logic [23:0] a, input int n, output logic [7:0] q [4], output logic oe_all);
    logic [7:0] r; logic s;
    oe_all = 1'b1;
    sel(); xb(8'h03, r, s); xb(a[23:16], r, s); xb(a[15:8], r, s); xb(a[7:0], r, s);
    for (int k = 0; k < n; k++) begin xb(8'h00, q[k], s); oe_all = oe_all & s; end
    desel();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int g = 0; g < 100; g++) begin rdsr(st); if (!st[0]) break; end
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    op1(8'h06); opa(8'h02, a, 1'b1, d); wait_idle();
  endtask

  task automatic rd1(input logic [23:0] a, output logic [7:0] v);
    logic [7:0] q [4]; logic o;
    rd(a, 1, q, o); v = q[0];
  endtask

  task automatic t_reset();
    logic [7:0] st, v;
    repeat (5) @(posedge clk); #1 rst_n = 1'b1;
    chk("R1 idle oe", {7'd0, oe}, 8'h00);
    rdsr(st); chk("R12 busy during power-up sweep", {7'd0, st[0]}, 8'h01);
    wait_idle();
    rdsr(st); chk("R3 status after sweep", st, 8'h00);
    rd1(24'h000000, v); chk("R9 erased at 000", v, 8'hFF);
    rd1(24'h0003FF, v); chk("R9 erased at 3FF", v, 8'hFF);
  endtask

  task automatic t_wel();
    logic [7:0] r, a, b, c; logic s;
    logic [7:0] v;
    opa(8'h02, 24'h000010, 1'b1, 8'h00); wait_idle();
    rd1(24'h000010, v); chk("R5 program without latch ignored", v, 8'hFF);
    op1(8'h06);
    sel(); xb(8'h05, r, s); xb(0, a, s); xb(0, b, s); xb(0, c, s); desel();
    chk("R4 latch set", a, 8'h02);
    chk("R3 status stream byte 2", b, 8'h02);
    chk("R3 status stream byte 3", c, 8'h02);
    op1(8'h04); rdsr(r); chk("R4 latch cleared", r, 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] v, st;
    prog(24'hFFFC10, 8'hA5);
    rdsr(st); chk("R5 latch cleared after program", st, 8'h00);
    rd1(24'h000010, v); chk("R6 upper address bits ignored", v, 8'hA5);
    prog(24'h000010, 8'h0F);
    rd1(24'h000010, v); chk("R6 program ANDs into old data", v, 8'h05);
  endtask

  task automatic t_read_wrap();
    logic [7:0] q [4]; logic o;
    prog(24'h0003FF, 8'h3C);
    rd(24'h0003FE, 3, q, o);
    chk("R7 read 3FE", q[0], 8'hFF);
    chk("R7 read 3FF", q[1], 8'h3C);
    chk("R7 read wraps to 000", q[2], 8'hFF);
    chk("R1 oe during read output", {7'd0, o}, 8'h01);
  endtask

  task automatic t_aai();
    logic [7:0] st; logic [7:0] q [4]; logic o;
    op1(8'h06); opa(8'hAF, 24'h000200, 1'b1, 8'h11); wait_idle();
    rdsr(st); chk("R8 sequential mode status", st, 8'h42);
    op2(8'hAF, 8'h22); wait_idle();
    op2(8'hAF, 8'h33); wait_idle();
    rd(24'h000200, 1, q, o); chk("R8 read refused in sequential mode", {7'd0, o}, 8'h00);
    opa(8'h02, 24'h000204, 1'b1, 8'h00); wait_idle();
    op1(8'h04); rdsr(st); chk("R4 write disable leaves sequential mode", st, 8'h00);
    rd(24'h000200, 4, q, o);
    chk("R8 first byte", q[0], 8'h11);
    chk("R8 second byte", q[1], 8'h22);
    chk("R8 third byte", q[2], 8'h33);
    chk("R8 next address untouched", q[3], 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] st, r; logic s;
    sel();
    for (int i = 7; i >= 3; i--) begin
      mosi = 1'(8'h06 >> i); repeat (3) @(posedge clk); #1 sck = 1'b1;
      repeat (3) @(posedge clk); #1 sck = 1'b0;
    end
    desel();
    rdsr(st); chk("R2 partial byte discarded", st, 8'h00);
    sel(); xb(8'h06, r, s); xb(8'h00, r, s); desel();
    rdsr(st); chk("R2 extra byte discards instruction", st, 8'h00);
  endtask

  task automatic t_erase();
    logic [7:0] v, st;
    prog(24'h000045, 8'h12);
    prog(24'h000085, 8'h34);
    opa(8'h20, 24'h000050, 1'b0, 8'h00); wait_idle();
    rd1(24'h000045, v); chk("R5 sector erase without latch ignored", v, 8'h12);
    op1(8'h06); opa(8'h20, 24'h000050, 1'b0, 8'h00); wait_idle();
    rd1(24'h000045, v); chk("R9 sector erased", v, 8'hFF);
    rd1(24'h000085, v); chk("R9 next sector kept", v, 8'h34);
    rd1(24'h000010, v); chk("R9 lower sector kept", v, 8'h05);
    rdsr(st); chk("R5 latch cleared after erase", st, 8'h00);
    op1(8'h06); opa(8'h52, 24'h0001C0, 1'b0, 8'h00); wait_idle();
    rd1(24'h000085, v); chk("R9 block erased 085", v, 8'hFF);
    rd1(24'h000010, v); chk("R9 block erased 010", v, 8'hFF);
    rd1(24'h000200, v); chk("R9 other block kept", v, 8'h11);
    op1(8'h06); op1(8'h60);
    rdsr(st); chk("R12 busy during chip erase", {7'd0, st[0]}, 8'h01);
    op1(8'h06);
    wait_idle();
    rdsr(st); chk("R12 command ignored while busy", st, 8'h00);
    rd1(24'h000200, v); chk("R9 chip erased 200", v, 8'hFF);
    rd1(24'h0003FF, v); chk("R9 chip erased 3FF", v, 8'hFF);
  endtask

  task automatic t_status();
    logic [7:0] st;
    op2(8'h01, 8'h3C); rdsr(st); chk("R10 unpaired status write ignored", st, 8'h00);
    op1(8'h50); op2(8'h01, 8'h3C); rdsr(st); chk("R10 paired status write", st, 8'h3C);
    op1(8'h50); op1(8'h06); op2(8'h01, 8'h00); rdsr(st); chk("R10 pairing broken by other command", st, 8'h3E);
    op1(8'h04);
    op1(8'h50); op2(8'h01, 8'hFF); rdsr(st); chk("R10 only bits 7 and 5:2 written", st, 8'hBC);
    op1(8'h50); op2(8'h01, 8'h00); rdsr(st); chk("R10 status cleared", st, 8'h00);
  endtask

  task automatic t_id();
    logic [7:0] r, a, b, c; logic s;
    sel(); xb(8'h90, r, s); xb(0, r, s); xb(0, r, s); xb(8'h01, r, s);
    xb(0, a, s); xb(0, b, s); xb(0, c, s); desel();
    chk("R11 device id", a, 8'h48);
    chk("R11 alternates to maker id", b, 8'hC5);
    chk("R11 alternates back", c, 8'h48);
    sel(); xb(8'hAB, r, s); xb(0, r, s); xb(0, r, s); xb(8'h00, r, s);
    xb(0, a, s); xb(0, b, s); desel();
    chk("R11 maker id", a, 8'hC5);
    chk("R11 device id follows", b, 8'h48);
    chk("R1 oe during id output", {7'd0, s}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_wel();
    t_program();
    t_read_wrap();
    t_aai();
    t_abort();
    t_erase();
    t_status();
    t_id();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule